// File: doc/BRIEF.md
# Sense Data Serial Transmitter (I2S / Left-Justified)

This block is a slave transmitter that places two sense channels, a load-voltage word and a load-current word, on a two-channel serial audio link. An external master supplies the bit clock and the word clock. The block returns one serial data line that changes on falling bit-clock edges, so a receiver can latch it on rising edges. The voltage word is sent while the word clock is low. The current word is sent while the word clock is high.

A 3-bit mode input selects the framing. In I2S framing the MSB follows the word-clock transition by one bit period. In left-justified framing the MSB takes the first bit period after the transition. In the supply-append modes, an 8-bit supply reading follows the voltage word, which makes the voltage channel 24 bits long. The current channel always stays at 16 bits. A low-power I2S mode runs with 32 bit clocks per frame. In that mode each 16-bit word plus its one-bit delay overruns its half-frame by one bit, so the LSB goes out in the first bit period of the next half-frame.

The control is a three-state machine:
- IDLE: from reset until the first word-clock transition.
- SHIFT: a word is being serialised.
- TAIL: the word is done and the line is held low.

It has these transitions:
- IDLE→SHIFT: on a transition.
- SHIFT→TAIL: after the last bit.
- SHIFT→SHIFT and TAIL→SHIFT: on each later transition, which reloads the word.

Top module: `sense_i2s_tx`

## Requirements
- R1: While reset is asserted, and after reset until the first word-clock transition is seen, `sdata_o` is 0.
- R2: The half-frame that follows a transition to word clock low carries `volt_i`. The half-frame that follows a transition to word clock high carries `curr_i`. Both are sent MSB first.
- R3: In I2S framing (mode 0, 2 or 4), the MSB is driven one bit period after the word-clock transition. The first bit period carries 0, or carries the carried-over bit described in R7.
- R4: In left-justified framing (mode 1 or 3), the MSB is driven in the first bit period after the word-clock transition.
- R5: In the supply-append modes (mode 2 and 3), the voltage channel sends 24 bits: `volt_i` as the 16 MSBs, then `supply_i` as the 8 LSBs. The current channel sends 16 bits.
- R6: Every bit period after the last data bit of a word, up to the next word-clock transition, carries 0.
- R7: In I2S framing, if a word still has exactly one bit unsent when the next transition arrives (as with 32 bit clocks per frame in mode 4), that bit is driven in the first bit period of the new half-frame. In left-justified framing, an unsent bit is dropped.
- R8: Mode and data inputs are captured at the word-clock transition. Changes to them later in the same half-frame do not alter the bits being sent.
- R9: Mode values 5, 6 and 7 behave like mode 0 (I2S, no supply byte).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Bit clock from the link master. All state updates on its falling edge. |
| rst_ni | input | 1 | Asynchronous active-low reset. |
| wclk_i | input | 1 | Word clock. Low selects the voltage channel, high selects the current channel. |
| mode_i | input | 3 | Framing mode: 0 I2S, 1 left-justified, 2 I2S with supply, 3 left-justified with supply, 4 low-power I2S. |
| volt_i | input | VW (16) | Voltage sense word. |
| curr_i | input | IW (16) | Current sense word. |
| supply_i | input | SW (8) | Supply sense byte. |
| sdata_o | output | 1 | Serial data, updated on falling bit-clock edges. |

## Verification
The bench builds the block with its default widths: 16-bit voltage and current words and an 8-bit supply byte. With these widths a 24-bit voltage word leaves 7 trailing zero bits in a 32-bit I2S half-frame and 8 in a left-justified one. They also make the 32-clock low-power frame overrun by exactly one bit, so the carried-over LSB of R7 appears in every low-power frame. Random frames mix all eight mode codes, switch between 32- and 64-clock frames, and disturb the inputs in mid-word.

// File: rtl/sense_tx_pkg.sv
package sense_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } tx_state_e;

    // Mode codes 1 and 3 use left-justified framing; all others use I2S.
    function automatic logic mode_is_lj(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd3);
    endfunction

    // Mode codes 2 and 3 append the supply byte to the voltage word.
    function automatic logic mode_has_supply(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd3);
    endfunction

endpackage

// File: rtl/stx_wclk_edge.sv
module stx_wclk_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wclk_i,
    output logic edge_o
);
    logic prev_q;
    logic primed_q;

    // The first falling edge after reset records the level; no edge before that.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= wclk_i;
            primed_q <= 1'b1;
        end
    end

    assign edge_o = primed_q && (wclk_i != prev_q);

endmodule

// File: rtl/stx_word_build.sv
module stx_word_build #(
    parameter int VW   = 16,
    parameter int IW   = 16,
    parameter int SW   = 8,
    parameter int WMAX = VW + SW,
    parameter int CW   = $clog2(WMAX + 1)
) (
    input  logic            chan_hi_i,
    input  logic [2:0]      mode_i,
    input  logic [VW-1:0]   volt_i,
    input  logic [IW-1:0]   curr_i,
    input  logic [SW-1:0]   supply_i,
    output logic [WMAX-1:0] word_o,
    output logic [CW-1:0]   len_o,
    output logic            lj_o
);
    import sense_tx_pkg::*;

    // Words are left-aligned in WMAX bits so the serializer always takes the top bit.
    always_comb begin
        lj_o = mode_is_lj(mode_i);
        if (chan_hi_i) begin
            word_o = WMAX'(curr_i) << (WMAX - IW);
            len_o  = CW'(IW);
        end else if (mode_has_supply(mode_i)) begin
            word_o = {volt_i, supply_i};
            len_o  = CW'(VW + SW);
        end else begin
            word_o = WMAX'(volt_i) << SW;
            len_o  = CW'(VW);
        end
    end

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer #(
    parameter int WMAX = 24,
    parameter int CW   = $clog2(WMAX + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   edge_i,
    input  logic                   lj_i,
    input  logic [WMAX-1:0]        word_i,
    input  logic [CW-1:0]          len_i,
    output logic                   sdata_o,
    output sense_tx_pkg::tx_state_e state_o
);
    import sense_tx_pkg::*;

    tx_state_e       state_q, state_nx;
    logic [WMAX-1:0] shreg_q;
    logic [CW-1:0]   left_q;

    // State register
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (edge_i) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (edge_i)                   state_nx = ST_SHIFT;
                else if (left_q == CW'(1))    state_nx = ST_TAIL;
            end
            ST_TAIL:  if (edge_i) state_nx = ST_SHIFT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Output and shift datapath
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sdata_o <= 1'b0;
            shreg_q <= '0;
            left_q  <= '0;
        end else if (edge_i) begin
            if (lj_i) begin
                sdata_o <= word_i[WMAX-1];
                shreg_q <= word_i << 1;
                left_q  <= len_i - CW'(1);
            end else begin
                // Delay slot: carries a single unsent bit of the previous word, if any.
                sdata_o <= (state_q == ST_SHIFT && left_q == CW'(1)) ? shreg_q[WMAX-1] : 1'b0;
                shreg_q <= word_i;
                left_q  <= len_i;
            end
        end else if (state_q == ST_SHIFT) begin
            sdata_o <= shreg_q[WMAX-1];
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - CW'(1);
        end else begin
            sdata_o <= 1'b0;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/sense_i2s_tx.sv
module sense_i2s_tx #(
    parameter int VW = 16,
    parameter int IW = 16,
    parameter int SW = 8
) (
    input  logic          bclk_i,
    input  logic          rst_ni,
    input  logic          wclk_i,
    input  logic [2:0]    mode_i,
    input  logic [VW-1:0] volt_i,
    input  logic [IW-1:0] curr_i,
    input  logic [SW-1:0] supply_i,
    output logic          sdata_o
);
    import sense_tx_pkg::*;

    localparam int WMAX = VW + SW;
    localparam int CW   = $clog2(WMAX + 1);

    logic            wc_edge;
    logic [WMAX-1:0] word;
    logic [CW-1:0]   word_len;
    logic            word_lj;
    tx_state_e       tx_state;
    logic            tail_flag;

    stx_wclk_edge u_edge (
        .clk_i  (bclk_i),
        .rst_ni (rst_ni),
        .wclk_i (wclk_i),
        .edge_o (wc_edge)
    );

    stx_word_build #(.VW(VW), .IW(IW), .SW(SW), .WMAX(WMAX), .CW(CW)) u_build (
        .chan_hi_i (wclk_i),
        .mode_i    (mode_i),
        .volt_i    (volt_i),
        .curr_i    (curr_i),
        .supply_i  (supply_i),
        .word_o    (word),
        .len_o     (word_len),
        .lj_o      (word_lj)
    );

    stx_serializer #(.WMAX(WMAX), .CW(CW)) u_ser (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .edge_i  (wc_edge),
        .lj_i    (word_lj),
        .word_i  (word),
        .len_i   (word_len),
        .sdata_o (sdata_o),
        .state_o (tx_state)
    );

    assign tail_flag = (tx_state == ST_TAIL);

endmodule

// File: rtl/sense_i2s_tx_chk.sv
module sense_i2s_tx_chk #(
    parameter int VW = 16,
    parameter int IW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wclk_i,
    input logic [2:0]    mode_i,
    input logic [VW-1:0] volt_i,
    input logic [IW-1:0] curr_i,
    input logic          sdata_i,
    input logic          edge_i,
    input logic          tail_i
);
    logic started_q;
    logic lj_w;

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) started_q <= 1'b0;
        else         started_q <= started_q | edge_i;
    end

    assign lj_w = (mode_i == 3'd1) || (mode_i == 3'd3);

    // R1
    idle_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (!started_q && !edge_i) |=> (sdata_i == 1'b0));

    // R6
    tail_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (tail_i && !edge_i) |=> (sdata_i == 1'b0));

    // R4
    lj_volt_msb_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (edge_i && lj_w && !wclk_i) |=> (sdata_i == $past(volt_i[VW-1])));

    // R2
    lj_curr_msb_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (edge_i && lj_w && wclk_i) |=> (sdata_i == $past(curr_i[IW-1])));

    // R3
    i2s_volt_msb_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (edge_i && !lj_w && !wclk_i) |=> ##1 (sdata_i == $past(volt_i[VW-1], 2)));

endmodule

bind sense_i2s_tx sense_i2s_tx_chk #(.VW(VW), .IW(IW)) u_chk (
    .clk_i   (bclk_i),
    .rst_ni  (rst_ni),
    .wclk_i  (wclk_i),
    .mode_i  (mode_i),
    .volt_i  (volt_i),
    .curr_i  (curr_i),
    .sdata_i (sdata_o),
    .edge_i  (wc_edge),
    .tail_i  (tail_flag)
);

// File: tb/sim_sense_i2s_tx.sv
module sim_sense_i2s_tx;
    localparam int CLK_PERIOD = 20;
    localparam int VW = 16;
    localparam int IW = 16;
    localparam int SW = 8;
    localparam int WM = VW + SW;

    logic          bclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wclk = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [VW-1:0] volt = '0;
    logic [IW-1:0] curr = '0;
    logic [SW-1:0] sup  = '0;
    logic          sdata;

    int   checks = 0;
    int   fails  = 0;
    int   left_n = 0;
    logic left_bit = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    sense_i2s_tx u0 (
        .bclk_i   (bclk),
        .rst_ni   (rst_n),
        .wclk_i   (wclk),
        .mode_i   (mode),
        .volt_i   (volt),
        .curr_i   (curr),
        .supply_i (sup),
        .sdata_o  (sdata)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Expected word per R2/R5: left-aligned in WM bits.
    function automatic logic [WM-1:0] bword(input logic hi, input logic [2:0] md,
                                            input logic [VW-1:0] v, input logic [IW-1:0] c,
                                            input logic [SW-1:0] s);
        if (hi) return {c, {(WM-IW){1'b0}}};
        if (md == 3'd2 || md == 3'd3) return {v, s};
        return {v, {SW{1'b0}}};
    endfunction

    function automatic int blen(input logic hi, input logic [2:0] md);
        if (hi) return IW;
        return (md == 3'd2 || md == 3'd3) ? VW + SW : VW;
    endfunction

    task automatic half(input logic lvl, input int hl, input logic [2:0] md,
                        input logic [VW-1:0] v, input logic [IW-1:0] c,
                        input logic [SW-1:0] s, input bit disturb);
        logic [WM-1:0] w;
        int  ln;
        bit  lj;
        int  d;
        lj = (md == 3'd1) || (md == 3'd3);
        d  = lj ? 0 : 1;
        w  = bword(lvl, md, v, c, s);
        ln = blen(lvl, md);
        for (int p = 0; p < hl; p++) begin
            logic  e;
            string tag;
            int    i;
            @(posedge bclk);
            if (p == 0) begin
                wclk = lvl; mode = md; volt = v; curr = c; sup = s;
            end else if (disturb && p == hl/2) begin
                mode = 3'($urandom); volt = VW'($urandom);
                curr = IW'($urandom); sup = SW'($urandom);
            end
            @(negedge bclk);
            #(CLK_PERIOD/4);
            i = p - d;
            if (i >= 0 && i < ln) begin
                e = w[WM-1-i];
                if (i == 0)                  tag = lj ? "R4" : "R3";
                else if (!lvl && i >= VW)    tag = "R5";
                else                         tag = "R2";
                if (md >= 3'd5)              tag = "R9";
            end else if (p == 0 && !lj && left_n == 1) begin
                e = left_bit; tag = "R7";
            end else begin
                e = 1'b0; tag = (p == 0 && !lj) ? "R3" : "R6";
            end
            if (disturb && p > hl/2) tag = "R8";
            chk(sdata, e, tag, $sformatf("mode %0d chan %0d pos %0d", md, lvl, p));
        end
        left_n   = d + ln - hl;
        left_bit = w[WM-ln];
    endtask

    task automatic frame(input logic [2:0] md, input int hl, input logic [VW-1:0] v,
                         input logic [IW-1:0] c, input logic [SW-1:0] s, input bit disturb);
        half(1'b1, hl, md, v, c, s, disturb);
        half(1'b0, hl, md, v, c, s, disturb);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: reset state
        repeat (3) begin
            @(negedge bclk);
            #(CLK_PERIOD/4);
            chk(sdata, 1'b0, "R1", "during reset");
        end
        @(posedge bclk);
        rst_n = 1'b1;
        // R1: idle after reset, data inputs moving, no word clock edge
        repeat (6) begin
            @(posedge bclk);
            volt = 16'hFFFF; curr = 16'hFFFF; mode = 3'($urandom);
            @(negedge bclk);
            #(CLK_PERIOD/4);
            chk(sdata, 1'b0, "R1", "idle before first edge");
        end
        // Directed corners
        frame(3'd0, 32, 16'hA5C3, 16'h5A3C, 8'h81, 1'b0);
        frame(3'd1, 32, 16'h8001, 16'hFFFF, 8'h7E, 1'b0);
        frame(3'd2, 32, 16'h0001, 16'h8000, 8'hFF, 1'b0);
        frame(3'd3, 32, 16'hFFFF, 16'h1234, 8'h01, 1'b0);
        frame(3'd4, 16, 16'h8001, 16'h0001, 8'h00, 1'b0);
        frame(3'd4, 16, 16'h7FFF, 16'hC001, 8'h00, 1'b0);
        frame(3'd4, 16, 16'h0003, 16'hFFFF, 8'h00, 1'b0);
        frame(3'd4, 32, 16'hBEEF, 16'hCAFE, 8'h55, 1'b0);
        frame(3'd6, 32, 16'h9C31, 16'h4E7B, 8'hAA, 1'b0);
        frame(3'd0, 32, 16'hF00F, 16'h0FF0, 8'h3C, 1'b1);
        frame(3'd3, 32, 16'h1357, 16'h2468, 8'hC3, 1'b1);
        // Random frames
        repeat (40) begin
            logic [2:0] md;
            int hl;
            md = 3'($urandom);
            hl = (md == 3'd4 && ($urandom % 2) == 0) ? 16 : 32;
            frame(md, hl, VW'($urandom), IW'($urandom), SW'($urandom), ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule